// File: doc/BRIEF.md
# Frame Memory Rectangle Transfer Address Generator

This block turns a rectangle description into the sequence of pixel addresses needed to move that rectangle between a 32-bit data stream and a frame memory of 1024 x 512 halfword pixels. The caller gives one position word and one size word with a start strobe, and says whether the transfer reads from or writes to the memory. The block then takes one 32-bit data word per accepted handshake. It splits each word into two 16-bit pixels and presents both pixel addresses one cycle later. The addresses follow the rectangle row by row.

The data stream may pause at any point, including in the middle of a row. The column offset, the current row and the number of rows left are all held across the pause, so the next burst picks up at the next pixel. For a read, the block raises a one-cycle prefetch strobe with the start address straight after the start, so the memory can place the first word ahead of the stream. A one-cycle done pulse marks the word that carries the last pixel.

Top module: `rxa_xfer_agen`

## Requirements
- R1: After reset, word_rdy_o, done_o, pf_vld_o and every bit of pix_vld_o are 0.
- R2: The start column is pos_i[9:0] and the start row is pos_i[24:16]. All other position bits are ignored. The address of a pixel is row*1024 + column.
- R3: The width is size_i[9:0], and a value of 0 means 1024. Bits 15:10 are ignored.
- R4: The height is size_i[24:16], and a value of 0 means 512. Bits 31:25 are ignored.
- R5: Each accepted word yields two pixels one cycle later. Lane 0 carries word bits 15:0 at the earlier walk position. Lane 1 carries bits 31:16 at the next position.
- R6: Pixels advance along a row. After width pixels, the column returns to the start column and the row increments. The column wraps modulo 1024 and the row wraps modulo 512.
- R7: Cycles with word_vld_i low produce no pixels and keep the walk position, so a pause in mid-row resumes at the next pixel.
- R8: done_o pulses for one cycle together with the pixels of the word that carries the final pixel. When the pixel total is odd, lane 1 of that word is invalid. After done_o, word_rdy_o is 0.
- R9: Words offered while word_rdy_o is 0 produce no pixel and no done pulse.
- R10: A start with start_read_i high gives pf_vld_o for one cycle in the next cycle, with pf_addr_o equal to the start address and read_o high. The walk does not advance.
- R11: A start during an unfinished transfer drops it and begins the new rectangle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Load a new rectangle |
| start_read_i | input | 1 | Direction of the new transfer (1 = memory read) |
| pos_i | input | 32 | Position word |
| size_i | input | 32 | Size word |
| word_vld_i | input | 1 | A data word is offered |
| word_i | input | 32 | Data word (two pixels) |
| word_rdy_o | output | 1 | Transfer in progress, words accepted |
| read_o | output | 1 | Direction of the current transfer |
| pix_vld_o | output | 2 | Per-lane pixel valid |
| pix_addr_o | output | 38 | Per-lane pixel address, lane 0 in the low 19 bits |
| pix_data_o | output | 32 | Per-lane pixel data, lane 0 in the low 16 bits |
| done_o | output | 1 | Final pixel presented this cycle |
| pf_vld_o | output | 1 | Read prefetch strobe |
| pf_addr_o | output | 19 | Read prefetch address |

## Verification
word_rdy_o rises in the cycle after a start is clocked in. pf_vld_o and pf_addr_o are valid for that same single cycle. The pixel lanes and done_o belong to the cycle after the edge that accepts a word. The bench drives every input on the falling edge. It reads each result at the first falling edge after the edge that accepts its stimulus, so each check compares the register stage that is due there. During each inserted pause, the bench checks that all lanes stay quiet. It then compares the next word against the pixel index that the pause should have preserved.

// File: rtl/rxa_pkg.sv
package rxa_pkg;
   // Bit position of the second field in both control words.
   localparam int unsigned HI_FIELD_LSB = 16;
   // Widest field the 16-bit halves can carry.
   localparam int unsigned MAX_FIELD_W  = 16;

   typedef enum logic {
      XFER_WRITE = 1'b0,
      XFER_READ  = 1'b1
   } xfer_dir_e;
endpackage

// File: rtl/rxa_size_decode.sv
module rxa_size_decode #(
   parameter int unsigned XBITS = 10,
   parameter int unsigned YBITS = 9
) (
   input  logic [31:0]      pos_i,
   input  logic [31:0]      size_i,
   output logic [XBITS-1:0] x0_o,
   output logic [YBITS-1:0] y0_o,
   output logic [XBITS:0]   wid_o,
   output logic [YBITS:0]   hgt_o
);
   import rxa_pkg::*;

   localparam logic [XBITS:0] WID_FULL = {1'b1, {XBITS{1'b0}}};
   localparam logic [YBITS:0] HGT_FULL = {1'b1, {YBITS{1'b0}}};

   logic [XBITS-1:0] w_field;
   logic [YBITS-1:0] h_field;
   logic             unused_bits;

   // (v - 1) masked, then + 1, reduces to: 0 means full span.
   assign w_field = size_i[XBITS-1:0];
   assign h_field = size_i[HI_FIELD_LSB +: YBITS];

   assign x0_o  = pos_i[XBITS-1:0];
   assign y0_o  = pos_i[HI_FIELD_LSB +: YBITS];
   assign wid_o = (w_field == '0) ? WID_FULL : {1'b0, w_field};
   assign hgt_o = (h_field == '0) ? HGT_FULL : {1'b0, h_field};

   assign unused_bits = ^{pos_i, size_i};
endmodule

// File: rtl/rxa_pixel_step.sv
module rxa_pixel_step #(
   parameter int unsigned XBITS = 10,
   parameter int unsigned YBITS = 9
) (
   input  logic [XBITS-1:0]       x0_i,
   input  logic [XBITS:0]         wid_i,
   input  logic [XBITS-1:0]       ofs_i,
   input  logic [YBITS-1:0]       row_i,
   input  logic [YBITS:0]         left_i,
   output logic                   live_o,
   output logic [XBITS+YBITS-1:0] addr_o,
   output logic [XBITS-1:0]       ofs_o,
   output logic [YBITS-1:0]       row_o,
   output logic [YBITS:0]         left_o
);
   logic [XBITS-1:0] col;
   logic [XBITS:0]   ofs_inc;
   logic             row_end;

   assign live_o  = (left_i != '0);
   assign col     = x0_i + ofs_i;
   assign addr_o  = {row_i, col};
   assign ofs_inc = {1'b0, ofs_i} + 1'b1;
   assign row_end = (ofs_inc == wid_i);

   always_comb begin
      ofs_o  = ofs_i;
      row_o  = row_i;
      left_o = left_i;
      if (live_o) begin
         if (row_end) begin
            ofs_o  = '0;
            row_o  = row_i + 1'b1;
            left_o = left_i - 1'b1;
         end else begin
            ofs_o = ofs_inc[XBITS-1:0];
         end
      end
   end
endmodule

// File: rtl/rxa_xfer_agen.sv
module rxa_xfer_agen #(
   parameter int unsigned XBITS = 10,
   parameter int unsigned YBITS = 9,
   parameter int unsigned PIXW  = 16,
   parameter int unsigned LANES = 2
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         start_i,
   input  logic                         start_read_i,
   input  logic [31:0]                  pos_i,
   input  logic [31:0]                  size_i,
   input  logic                         word_vld_i,
   input  logic [LANES*PIXW-1:0]        word_i,
   output logic                         word_rdy_o,
   output logic                         read_o,
   output logic [LANES-1:0]             pix_vld_o,
   output logic [LANES*(XBITS+YBITS)-1:0] pix_addr_o,
   output logic [LANES*PIXW-1:0]        pix_data_o,
   output logic                         done_o,
   output logic                         pf_vld_o,
   output logic [XBITS+YBITS-1:0]       pf_addr_o
);
   import rxa_pkg::*;

   localparam int unsigned AW = XBITS + YBITS;

   generate
      if (XBITS < 1 || XBITS > MAX_FIELD_W) begin : g_bad_x
         $error("XBITS must lie in 1..16");
      end
      if (YBITS < 1 || YBITS > MAX_FIELD_W) begin : g_bad_y
         $error("YBITS must lie in 1..16");
      end
      if (LANES < 1 || LANES > 4) begin : g_bad_lanes
         $error("LANES must lie in 1..4");
      end
   endgenerate

   // decoded start parameters
   logic [XBITS-1:0] dec_x0;
   logic [YBITS-1:0] dec_y0;
   logic [XBITS:0]   dec_wid;
   logic [YBITS:0]   dec_hgt;

   rxa_size_decode #(.XBITS(XBITS), .YBITS(YBITS)) u_dec (
      .pos_i  (pos_i),
      .size_i (size_i),
      .x0_o   (dec_x0),
      .y0_o   (dec_y0),
      .wid_o  (dec_wid),
      .hgt_o  (dec_hgt)
   );

   // walk state
   logic [XBITS-1:0] x0_q;
   logic [XBITS:0]   wid_q;
   logic [XBITS-1:0] ofs_q;
   logic [YBITS-1:0] row_q;
   logic [YBITS:0]   left_q;
   xfer_dir_e        dir_q;
   logic             busy;

   assign busy = (left_q != '0);

   // lane chain: one step per pixel of the word
   logic [XBITS-1:0] ofs_c  [LANES+1];
   logic [YBITS-1:0] row_c  [LANES+1];
   logic [YBITS:0]   left_c [LANES+1];
   logic [LANES-1:0] live_c;
   logic [AW-1:0]    addr_c [LANES];

   assign ofs_c[0]  = ofs_q;
   assign row_c[0]  = row_q;
   assign left_c[0] = left_q;

   generate
      for (genvar l = 0; l < LANES; l++) begin : g_lane
         rxa_pixel_step #(.XBITS(XBITS), .YBITS(YBITS)) u_step (
            .x0_i   (x0_q),
            .wid_i  (wid_q),
            .ofs_i  (ofs_c[l]),
            .row_i  (row_c[l]),
            .left_i (left_c[l]),
            .live_o (live_c[l]),
            .addr_o (addr_c[l]),
            .ofs_o  (ofs_c[l+1]),
            .row_o  (row_c[l+1]),
            .left_o (left_c[l+1])
         );
      end
   endgenerate

   logic              take;
   logic [LANES-1:0]  pv_q;
   logic [LANES*AW-1:0] pa_q;
   logic [LANES*PIXW-1:0] pd_q;
   logic              done_q;
   logic              pf_q;
   logic [AW-1:0]     pfa_q;

   assign take = word_vld_i && busy && !start_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         x0_q   <= '0;
         wid_q  <= '0;
         ofs_q  <= '0;
         row_q  <= '0;
         left_q <= '0;
         dir_q  <= XFER_WRITE;
         pf_q   <= 1'b0;
         pfa_q  <= '0;
      end else if (start_i) begin
         x0_q   <= dec_x0;
         wid_q  <= dec_wid;
         ofs_q  <= '0;
         row_q  <= dec_y0;
         left_q <= dec_hgt;
         dir_q  <= start_read_i ? XFER_READ : XFER_WRITE;
         pf_q   <= start_read_i;
         pfa_q  <= {dec_y0, dec_x0};
      end else begin
         pf_q <= 1'b0;
         if (take) begin
            ofs_q  <= ofs_c[LANES];
            row_q  <= row_c[LANES];
            left_q <= left_c[LANES];
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pv_q   <= '0;
         pa_q   <= '0;
         pd_q   <= '0;
         done_q <= 1'b0;
      end else if (take) begin
         pv_q   <= live_c;
         pd_q   <= word_i;
         done_q <= (left_c[LANES] == '0);
         for (int l = 0; l < LANES; l++) begin
            pa_q[l*AW +: AW] <= addr_c[l];
         end
      end else begin
         pv_q   <= '0;
         done_q <= 1'b0;
      end
   end

   assign word_rdy_o = busy;
   assign read_o     = (dir_q == XFER_READ);
   assign pix_vld_o  = pv_q;
   assign pix_addr_o = pa_q;
   assign pix_data_o = pd_q;
   assign done_o     = done_q;
   assign pf_vld_o   = pf_q;
   assign pf_addr_o  = pfa_q;

   // R8
   done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);
   // R8
   done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> !word_rdy_o || $past(start_i));
   // R9
   idle_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!word_rdy_o && word_vld_i && !start_i) |=> (pix_vld_o == '0) && !done_o);
   // R6
   ofs_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      word_rdy_o |-> ({1'b0, ofs_q} < wid_q));
   // R7
   pause_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!word_vld_i && !start_i) |=> $stable(ofs_q) && $stable(row_q) && $stable(left_q)
                                    && (pix_vld_o == '0));
   // R10
   pf_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pf_vld_o |-> $past(start_i && start_read_i));

   generate
      for (genvar l = 1; l < LANES; l++) begin : g_order_chk
         // R5
         lane_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
            pix_vld_o[l] |-> pix_vld_o[l-1]);
      end
   endgenerate
endmodule

// File: tb/tb_rxa_xfer_agen.sv
module tb_rxa_xfer_agen;
   localparam int CLK_PERIOD = 10;
   localparam int XB = 10;
   localparam int YB = 9;
   localparam int AW = XB + YB;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start_i = 1'b0;
   logic        start_read_i = 1'b0;
   logic [31:0] pos_i = '0;
   logic [31:0] size_i = '0;
   logic        word_vld_i = 1'b0;
   logic [31:0] word_i = '0;
   logic        word_rdy_o, read_o, done_o, pf_vld_o;
   logic [1:0]  pix_vld_o;
   logic [2*AW-1:0] pix_addr_o;
   logic [31:0] pix_data_o;
   logic [AW-1:0] pf_addr_o;

   int n_cmp = 0;
   int n_bad = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   rxa_xfer_agen #(.XBITS(XB), .YBITS(YB), .PIXW(16), .LANES(2)) dut (
      .clk, .rst_n, .start_i, .start_read_i, .pos_i, .size_i,
      .word_vld_i, .word_i, .word_rdy_o, .read_o, .pix_vld_o,
      .pix_addr_o, .pix_data_o, .done_o, .pf_vld_o, .pf_addr_o
   );

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   task automatic summary();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
   endtask

   function automatic int exp_addr(int x0, int y0, int w, int k);
      int x = (x0 + k % w) % 1024;
      int y = (y0 + k / w) % 512;
      return y * 1024 + x;
   endfunction

   // Runs one transfer; stop_after >= 0 abandons it after that many words.
   task automatic xfer(input logic [31:0] pos, input logic [31:0] size, input bit rd,
                       input int gapmod, input int stop_after);
      int x0 = int'(pos[9:0]);
      int y0 = int'(pos[24:16]);
      int w  = (size[9:0] == 0) ? 1024 : int'(size[9:0]);
      int h  = (size[24:16] == 0) ? 512 : int'(size[24:16]);
      int total = w * h;
      int nw = (total + 1) / 2;
      @(negedge clk);
      start_i = 1'b1; start_read_i = rd; pos_i = pos; size_i = size;
      @(negedge clk);
      start_i = 1'b0;
      chk("R11 ready after start", word_rdy_o, 1);
      chk("R10 prefetch strobe", pf_vld_o, rd);
      chk("R10 direction", read_o, rd);
      if (rd) chk("R10 prefetch address (R2)", pf_addr_o, exp_addr(x0, y0, w, 0));
      for (int j = 0; j < nw; j++) begin
         logic [15:0] lo = 16'(j * 2 + 7);
         logic [15:0] hi = 16'(j * 2 + 8);
         int k = 2 * j;
         if (stop_after >= 0 && j == stop_after) return;
         word_vld_i = 1'b1; word_i = {hi, lo};
         @(negedge clk);
         word_vld_i = 1'b0;
         chk("R5 lane0 valid", pix_vld_o[0], 1);
         chk("R6 lane0 address (R2 R3 R4)", pix_addr_o[AW-1:0], exp_addr(x0, y0, w, k));
         chk("R5 lane0 data", pix_data_o[15:0], lo);
         chk("R8 lane1 valid", pix_vld_o[1], (k + 1 < total));
         if (k + 1 < total) begin
            chk("R6 lane1 address", pix_addr_o[2*AW-1:AW], exp_addr(x0, y0, w, k + 1));
            chk("R5 lane1 data", pix_data_o[31:16], hi);
         end
         chk("R8 done timing", done_o, (j == nw - 1));
         if (gapmod > 0) begin
            for (int g = 0; g < j % gapmod; g++) begin
               @(negedge clk);
               chk("R7 quiet in pause", {pix_vld_o, done_o}, 0);
            end
         end
      end
      chk("R8 idle after done", word_rdy_o, 0);
   endtask

   initial begin
      #(CLK_PERIOD * 190000);
      n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      summary();
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1 reset state
      chk("R1 ready", word_rdy_o, 0);
      chk("R1 lanes", pix_vld_o, 0);
      chk("R1 done", done_o, 0);
      chk("R1 prefetch", pf_vld_o, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 ready after release", word_rdy_o, 0);

      // R2 R3 R4 R6 sweep of small rectangles, plain and at the wrap corner,
      // with junk in ignored position and size bits.
      for (int w = 1; w <= 6; w++) begin
         for (int h = 1; h <= 3; h++) begin
            xfer({7'h55, 9'd40, 6'h2A, 10'd100}, {7'h3F, 9'(h), 6'h15, 10'(w)}, 1'b0, 0, -1);
            xfer({7'h00, 9'd510, 6'h00, 10'd1021}, {7'h00, 9'(h), 6'h00, 10'(w)}, 1'b1, 3, -1);
         end
      end

      // R3 width zero means 1024 (column wrap from a nonzero start)
      xfer({7'h0, 9'd3, 6'h0, 10'd5}, {7'h0, 9'd2, 6'h0, 10'd0}, 1'b0, 5, -1);
      // R4 height zero means 512 (row wrap)
      xfer({7'h0, 9'd300, 6'h0, 10'd9}, {7'h0, 9'd0, 6'h0, 10'd1}, 1'b1, 0, -1);
      // R7 odd width with pauses that split rows mid-way
      xfer({7'h0, 9'd7, 6'h0, 10'd20}, {7'h0, 9'd4, 6'h0, 10'd7}, 1'b0, 4, -1);

      // R9 words while idle are ignored
      @(negedge clk);
      word_vld_i = 1'b1; word_i = 32'hDEAD_BEEF;
      @(negedge clk);
      chk("R9 no pixel while idle", pix_vld_o, 0);
      @(negedge clk);
      word_vld_i = 1'b0;
      chk("R9 no done while idle", done_o, 0);

      // R11 restart during a transfer
      xfer({7'h0, 9'd1, 6'h0, 10'd1}, {7'h0, 9'd5, 6'h0, 10'd9}, 1'b0, 0, 2);
      xfer({7'h0, 9'd200, 6'h0, 10'd600}, {7'h0, 9'd2, 6'h0, 10'd3}, 1'b1, 2, -1);

      summary();
      $finish;
   end
endmodule